// File: doc/BRIEF.md
# SCSI Controller Register and Interrupt Front-End

This block is the host-facing register file of a legacy SCSI protocol controller. A CPU reaches it through a small byte-wide address space. Inside are two images of sixteen byte registers: one holds what software last wrote, and the other holds what software reads back. The block owns the status, interrupt-cause and sequence-step registers. It drives a level interrupt line. It carries out the side effects of reads, decodes the commands written by software, and implements the hard reset and the soft reset.

The bus-phase engine and the data mover sit outside this block. They report their events through a one-cycle strobe that carries a cause byte and a status byte, and that strobe raises the interrupt. The block tells the data mover whether the last command asked for DMA.

The register index is the bus address shifted right by `IDX_SHIFT`. The index layout is: 0 count low, 1 count middle, 2 data port, 3 command, 4 status (read) / target id (write), 5 interrupt cause (read) / timeout (write), 6 sequence step (read) / sync period (write), 7 FIFO flags (read) / sync offset (write), 8 config 1, 9 clock factor, 10 test, 11 config 2, 12 config 3, 13 spare A, 14 count high, 15 spare B.

Top module: `scsi_reg_frontend`

## Requirements
- R1: Status bit 7 (interrupt pending) and `irq` always rise together. A raise request that arrives while bit 7 is already set leaves `irq` high and leaves bit 7 set.
- R2: A byte read of index 5 returns the cause value held before the read. The same access zeroes the cause register, clears status bit 4 (count zero), clears status bit 7, sets the sequence step (index 6) to 0x04 and lowers `irq`.
- R3: A write to any of the count registers (index 0, 1 or 14) clears status bit 4.
- R4: A command write with bit 7 set copies the last written count bytes into the readable count registers and sets `dma_mode`. A command write with bit 7 clear leaves the readable count untouched and clears `dma_mode`.
- R5: On `rst`, both images are cleared, index 14 then reads `CHIP_CODE`, index 8 reads 0x07, and `irq` and `dma_mode` are low.
- R6: The `ext_reset` pin held high, or command opcode 0x02, performs the R5 actions and lowers `irq`.
- R7: Command opcode 0x03 (bus reset) writes cause 0x80. It raises the interrupt only when bit 6 of the written config 1 value is clear.
- R8: Command opcode 0x01 (flush) sets the cause to 0x08 and zeroes the sequence step and the FIFO flags, and it does not raise the interrupt. Opcode 0x45 (drop selection) zeroes the cause and raises the interrupt.
- R9: Writes to indices 8, 11, 12, 13 and 15 read back. Writes to indices 2, 4–7, 9 and 10 change only the write image, and those indices read as 0 while no event has loaded them. Writes whose index is 16 or above are ignored, and reads there return 0.
- R10: Byte accesses (`bus_size`=00) are accepted in both directions. Word accesses (`bus_size`=10) are accepted only for writes, which use `bus_wdata[7:0]`. A rejected read raises no `bus_rvalid` and has no side effect.
- R11: `bus_rdata`, `bus_rvalid` and `irq` are registered and change at the clock edge that accepts the causing access or strobe.
- R12: An `ev_req` strobe loads `ev_cause` into the cause register and `ev_status` into the status register with bit 7 forced high, and it raises `irq`. A bus access in the same cycle is applied after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hard reset, active high |
| ext_reset | input | 1 | External reset pin, active high, synchronous soft reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 00 byte, 10 word |
| bus_addr | input | ADDR_W | Byte address; index = addr >> IDX_SHIFT |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | High for one cycle after an accepted read |
| ev_req | input | 1 | Sequencer interrupt request strobe |
| ev_cause | input | 8 | Cause value loaded by `ev_req` |
| ev_status | input | 8 | Status value loaded by `ev_req` |
| irq | output | 1 | Level interrupt |
| dma_mode | output | 1 | The last command carried the DMA flag |

## Verification
The assertions assume that `bus_valid` presents at most one access per cycle. They also assume that a read of the cause register never coincides with a sequencer strobe whose cause software still needs, because in that case the read wipes the new cause. The bench drives every access and every strobe in a cycle of its own, starting on the falling clock edge, and never overlaps a strobe with an access. Reset pulses are likewise kept apart from accesses, so each check sees exactly one cause.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int REG_COUNT = 16;
  localparam int IDX_W     = $clog2(REG_COUNT);

  localparam logic [IDX_W-1:0] RI_CNT_LO = 4'd0;
  localparam logic [IDX_W-1:0] RI_CNT_MD = 4'd1;
  localparam logic [IDX_W-1:0] RI_DPORT  = 4'd2;
  localparam logic [IDX_W-1:0] RI_CMD    = 4'd3;
  localparam logic [IDX_W-1:0] RI_STAT   = 4'd4;
  localparam logic [IDX_W-1:0] RI_CAUSE  = 4'd5;
  localparam logic [IDX_W-1:0] RI_STEP   = 4'd6;
  localparam logic [IDX_W-1:0] RI_FLAGS  = 4'd7;
  localparam logic [IDX_W-1:0] RI_CFG1   = 4'd8;
  localparam logic [IDX_W-1:0] RI_CLKF   = 4'd9;
  localparam logic [IDX_W-1:0] RI_TEST   = 4'd10;
  localparam logic [IDX_W-1:0] RI_CFG2   = 4'd11;
  localparam logic [IDX_W-1:0] RI_CFG3   = 4'd12;
  localparam logic [IDX_W-1:0] RI_SPA    = 4'd13;
  localparam logic [IDX_W-1:0] RI_CNT_HI = 4'd14;
  localparam logic [IDX_W-1:0] RI_SPB    = 4'd15;

  localparam int ST_INT_B     = 7;
  localparam int ST_TC_B      = 4;
  localparam int CFG1_NOREP_B = 6;
  localparam int CMD_DMA_B    = 7;

  localparam logic [7:0] CAUSE_FDONE = 8'h08;
  localparam logic [7:0] CAUSE_BRST  = 8'h80;
  localparam logic [7:0] STEP_DONE   = 8'h04;
  localparam logic [7:0] CFG1_INIT   = 8'h07;

  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_SOFTRST = 7'h02;
  localparam logic [6:0] OP_BUSRST  = 7'h03;
  localparam logic [6:0] OP_DROPSEL = 7'h45;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_FLUSH, ACT_SOFTRST, ACT_BUSRST, ACT_DROPSEL
  } cmd_act_e;
endpackage

// File: rtl/sfe_bus_decode.sv
module sfe_bus_decode
  import sfe_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IDX_SHIFT = 2
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic              in_range,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-1:0] shifted;

  always_comb begin
    shifted  = bus_addr >> IDX_SHIFT;
    in_range = shifted < ADDR_W'(REG_COUNT);
    idx      = shifted[IDX_W-1:0];
    acc_wr   = bus_valid && bus_write && (bus_size == SZ_BYTE || bus_size == SZ_WORD);
    acc_rd   = bus_valid && !bus_write && (bus_size == SZ_BYTE);
  end
endmodule

// File: rtl/sfe_cmd_decode.sv
module sfe_cmd_decode
  import sfe_pkg::*;
(
  input  logic [7:0] cmd,
  output logic       dma_flag,
  output cmd_act_e   act
);
  always_comb begin
    dma_flag = cmd[CMD_DMA_B];
    unique case (cmd[6:0])
      OP_FLUSH:   act = ACT_FLUSH;
      OP_SOFTRST: act = ACT_SOFTRST;
      OP_BUSRST:  act = ACT_BUSRST;
      OP_DROPSEL: act = ACT_DROPSEL;
      default:    act = ACT_NONE;
    endcase
  end
endmodule

// File: rtl/scsi_reg_frontend.sv
module scsi_reg_frontend
  import sfe_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         IDX_SHIFT = 2,
  parameter logic [7:0] CHIP_CODE = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_reset,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  input  logic              ev_req,
  input  logic [7:0]        ev_cause,
  input  logic [7:0]        ev_status,
  output logic              irq,
  output logic              dma_mode
);
  logic [7:0] rd_img [REG_COUNT];
  logic [7:0] wr_img [REG_COUNT];
  logic [7:0] rd_img_n [REG_COUNT];
  logic [7:0] wr_img_n [REG_COUNT];

  logic              irq_q, dma_q, rv_q, dma_n, rv_n, soft_n;
  logic [7:0]        rdat_q, rdat_n;
  logic              acc_wr, acc_rd, in_rng, dma_flag;
  logic [IDX_W-1:0]  idx;
  cmd_act_e          act;
  logic [7:0]        wbyte;
  logic              unused_wdata;
  logic              is_cmd_wr, is_cnt_wr, is_cause_rd;

  assign wbyte        = bus_wdata[7:0];
  assign unused_wdata = ^bus_wdata[31:8];

  sfe_bus_decode #(.ADDR_W(ADDR_W), .IDX_SHIFT(IDX_SHIFT)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .in_range(in_rng), .idx(idx)
  );

  sfe_cmd_decode u_cmd (.cmd(wbyte), .dma_flag(dma_flag), .act(act));

  assign is_cmd_wr   = acc_wr && in_rng && idx == RI_CMD;
  assign is_cnt_wr   = acc_wr && in_rng &&
                       (idx == RI_CNT_LO || idx == RI_CNT_MD || idx == RI_CNT_HI);
  assign is_cause_rd = acc_rd && in_rng && idx == RI_CAUSE;

  // Next-state: sequencer strobe first, bus access on top of it.
  always_comb begin
    rd_img_n = rd_img;
    wr_img_n = wr_img;
    dma_n    = dma_q;
    rdat_n   = rdat_q;
    rv_n     = 1'b0;
    soft_n   = 1'b0;

    if (ev_req) begin
      rd_img_n[RI_CAUSE] = ev_cause;
      rd_img_n[RI_STAT]  = ev_status | (8'h1 << ST_INT_B);
    end

    if (acc_rd) begin
      rv_n   = 1'b1;
      rdat_n = in_rng ? rd_img[idx] : 8'h00;
      if (is_cause_rd) begin
        rd_img_n[RI_CAUSE]          = 8'h00;
        rd_img_n[RI_STAT][ST_TC_B]  = 1'b0;
        rd_img_n[RI_STAT][ST_INT_B] = 1'b0;
        rd_img_n[RI_STEP]           = STEP_DONE;
      end
    end

    if (acc_wr && in_rng) begin
      wr_img_n[idx] = wbyte;
      unique case (idx)
        RI_CNT_LO, RI_CNT_MD, RI_CNT_HI: rd_img_n[RI_STAT][ST_TC_B] = 1'b0;
        RI_CFG1, RI_CFG2, RI_CFG3, RI_SPA, RI_SPB: rd_img_n[idx] = wbyte;
        RI_CMD: begin
          rd_img_n[RI_CMD] = wbyte;
          dma_n            = dma_flag;
          if (dma_flag) begin
            rd_img_n[RI_CNT_LO] = wr_img[RI_CNT_LO];
            rd_img_n[RI_CNT_MD] = wr_img[RI_CNT_MD];
            rd_img_n[RI_CNT_HI] = wr_img[RI_CNT_HI];
          end
          unique case (act)
            ACT_FLUSH: begin
              rd_img_n[RI_CAUSE] = CAUSE_FDONE;
              rd_img_n[RI_STEP]  = 8'h00;
              rd_img_n[RI_FLAGS] = 8'h00;
            end
            ACT_SOFTRST: soft_n = 1'b1;
            ACT_BUSRST: begin
              rd_img_n[RI_CAUSE] = CAUSE_BRST;
              if (!wr_img[RI_CFG1][CFG1_NOREP_B])
                rd_img_n[RI_STAT][ST_INT_B] = 1'b1;
            end
            ACT_DROPSEL: begin
              rd_img_n[RI_CAUSE]          = 8'h00;
              rd_img_n[RI_STAT][ST_INT_B] = 1'b1;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ext_reset || soft_n) begin
      for (int i = 0; i < REG_COUNT; i++) begin
        rd_img[i] <= 8'h00;
        wr_img[i] <= 8'h00;
      end
      rd_img[RI_CNT_HI] <= CHIP_CODE;
      rd_img[RI_CFG1]   <= CFG1_INIT;
      irq_q  <= 1'b0;
      dma_q  <= 1'b0;
      rv_q   <= 1'b0;
      rdat_q <= 8'h00;
    end else begin
      rd_img <= rd_img_n;
      wr_img <= wr_img_n;
      irq_q  <= rd_img_n[RI_STAT][ST_INT_B];
      dma_q  <= dma_n;
      rv_q   <= rv_n;
      rdat_q <= rdat_n;
    end
  end

  assign irq        = irq_q;
  assign dma_mode   = dma_q;
  assign bus_rvalid = rv_q;
  assign bus_rdata  = rdat_q;

  // R1: the interrupt rises only on a strobe or a command write
  a_r1_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ev_req || is_cmd_wr));

  // R2: a cause read lowers irq and leaves the done step with an empty cause
  a_r2_cause_read_clears: assert property (@(posedge clk) disable iff (rst)
    (is_cause_rd && !ext_reset) |=>
      (!irq && rd_img[RI_STEP] == STEP_DONE && rd_img[RI_CAUSE] == 8'h00));

  // R3: a count write leaves the count-zero bit clear
  a_r3_count_write_clears_tc: assert property (@(posedge clk) disable iff (rst)
    (is_cnt_wr && !ext_reset) |=> !rd_img[RI_STAT][ST_TC_B]);

  // R6: the reset pin restores the identification and config values
  a_r6_pin_reset: assert property (@(posedge clk) disable iff (rst)
    ext_reset |=> (!irq && !dma_mode && rd_img[RI_CFG1] == CFG1_INIT &&
                   rd_img[RI_CNT_HI] == CHIP_CODE));

  // R10: a word-sized read is never answered
  a_r10_word_read_rejected: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_size != SZ_BYTE) |=> !bus_rvalid);
endmodule

// File: tb/scsi_reg_frontend_tb.sv
module scsi_reg_frontend_tb;
  localparam int AW = 8;
  localparam int SH = 2;
  localparam logic [7:0] CHIP = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1, ext_reset = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0] bus_size = 2'b00;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_rvalid;
  logic ev_req = 1'b0;
  logic [7:0] ev_cause = '0, ev_status = '0;
  logic irq, dma_mode;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  scsi_reg_frontend #(.ADDR_W(AW), .IDX_SHIFT(SH), .CHIP_CODE(CHIP)) u_dut (
    .clk(clk), .rst(rst), .ext_reset(ext_reset), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ev_req(ev_req), .ev_cause(ev_cause), .ev_status(ev_status),
    .irq(irq), .dma_mode(dma_mode)
  );

  // {check, write, size[1:0], index[5:0], data[7:0], expected[7:0]}
  localparam int NV = 21;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b00, 6'd8,  8'h00, 8'h07},  // R5 config 1
    {1'b1, 1'b0, 2'b00, 6'd14, 8'h00, CHIP },  // R5 chip code
    {1'b1, 1'b0, 2'b00, 6'd4,  8'h00, 8'h00},  // R5 status
    {1'b0, 1'b1, 2'b00, 6'd11, 8'h3C, 8'h00},
    {1'b1, 1'b0, 2'b00, 6'd11, 8'h00, 8'h3C},  // R9 mirrored
    {1'b0, 1'b1, 2'b00, 6'd9,  8'h55, 8'h00},
    {1'b1, 1'b0, 2'b00, 6'd9,  8'h00, 8'h00},  // R9 write-only
    {1'b0, 1'b1, 2'b00, 6'd0,  8'h11, 8'h00},
    {1'b0, 1'b1, 2'b00, 6'd1,  8'h22, 8'h00},
    {1'b0, 1'b1, 2'b00, 6'd14, 8'h33, 8'h00},
    {1'b1, 1'b0, 2'b00, 6'd0,  8'h00, 8'h00},  // R4 not yet reloaded
    {1'b1, 1'b0, 2'b00, 6'd14, 8'h00, CHIP },  // R4 not yet reloaded
    {1'b0, 1'b1, 2'b00, 6'd3,  8'h80, 8'h00},  // DMA-flagged no-op
    {1'b1, 1'b0, 2'b00, 6'd0,  8'h00, 8'h11},  // R4 reload
    {1'b1, 1'b0, 2'b00, 6'd1,  8'h00, 8'h22},  // R4 reload
    {1'b1, 1'b0, 2'b00, 6'd14, 8'h00, 8'h33},  // R4 reload
    {1'b1, 1'b0, 2'b00, 6'd3,  8'h00, 8'h80},  // command readable
    {1'b0, 1'b1, 2'b10, 6'd13, 8'hAB, 8'h00},  // word write
    {1'b1, 1'b0, 2'b00, 6'd13, 8'h00, 8'hAB},  // R10 word write taken
    {1'b0, 1'b1, 2'b00, 6'd27, 8'hC3, 8'h00},  // out of range
    {1'b1, 1'b0, 2'b00, 6'd11, 8'h00, 8'h3C}   // R9 no alias
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input int ix,
                        input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = we; bus_size = sz;
    bus_addr = AW'(ix << SH); bus_wdata = {24'hA5A5A5, d};
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr(input int ix, input logic [7:0] d);
    access(1'b1, 2'b00, ix, d);
  endtask

  task automatic rd_chk(input string tag, input int ix, input logic [7:0] exp);
    access(1'b0, 2'b00, ix, 8'h00);
    chk({tag, " rvalid"}, {7'd0, bus_rvalid}, 8'h01);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic event_pulse(input logic [7:0] c, input logic [7:0] s);
    @(negedge clk);
    ev_req = 1'b1; ev_cause = c; ev_status = s;
    @(negedge clk);
    ev_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R5 irq after reset", {7'd0, irq}, 8'h00);
    chk("R5 dma_mode after reset", {7'd0, dma_mode}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][24], VEC[i][23:22], int'(VEC[i][21:16]), VEC[i][15:8]);
      if (VEC[i][25]) begin
        chk($sformatf("vector %0d rvalid", i), {7'd0, bus_rvalid}, 8'h01);
        chk($sformatf("vector %0d data", i), bus_rdata, VEC[i][7:0]);
      end
    end
    chk("R4 dma_mode set", {7'd0, dma_mode}, 8'h01);
    wr(3, 8'h00);
    chk("R4 dma_mode cleared", {7'd0, dma_mode}, 8'h00);
    rd_chk("R4 count kept", 0, 8'h11);

    // R12 / R11: strobe raises irq at the next edge
    event_pulse(8'h10, 8'h13);
    chk("R11 irq after strobe", {7'd0, irq}, 8'h01);
    rd_chk("R12 status loaded", 4, 8'h93);
    rd_chk("R2 cause prior value", 5, 8'h10);
    chk("R2 irq lowered", {7'd0, irq}, 8'h00);
    rd_chk("R2 tc and int cleared", 4, 8'h03);
    rd_chk("R2 step done", 6, 8'h04);
    rd_chk("R2 cause zeroed", 5, 8'h00);

    // R1: second raise while pending
    event_pulse(8'h20, 8'h00);
    event_pulse(8'h30, 8'h00);
    chk("R1 irq stays high", {7'd0, irq}, 8'h01);
    rd_chk("R1 status int kept", 4, 8'h80);
    rd_chk("R12 cause latest", 5, 8'h30);

    // R3
    event_pulse(8'h00, 8'h10);
    rd_chk("R3 tc set by strobe", 4, 8'h90);
    wr(1, 8'h44);
    rd_chk("R3 tc cleared by count write", 4, 8'h80);
    chk("R3 irq untouched", {7'd0, irq}, 8'h01);
    rd_chk("R3 clear cause", 5, 8'h00);

    // R7
    wr(3, 8'h03);
    chk("R7 bus reset raises", {7'd0, irq}, 8'h01);
    rd_chk("R7 cause", 5, 8'h80);
    wr(8, 8'h40);
    rd_chk("R9 config 1 mirrored", 8, 8'h40);
    wr(3, 8'h03);
    chk("R7 report disabled", {7'd0, irq}, 8'h00);
    rd_chk("R7 cause while disabled", 5, 8'h80);

    // R8
    wr(3, 8'h01);
    chk("R8 flush no irq", {7'd0, irq}, 8'h00);
    rd_chk("R8 flush step", 6, 8'h00);
    rd_chk("R8 flush flags", 7, 8'h00);
    rd_chk("R8 flush cause", 5, 8'h08);
    wr(3, 8'h45);
    chk("R8 drop-selection raises", {7'd0, irq}, 8'h01);
    rd_chk("R8 drop-selection status", 4, 8'h80);
    rd_chk("R8 drop-selection cause", 5, 8'h00);

    // R10: word read rejected without side effect
    event_pulse(8'h55, 8'h00);
    access(1'b0, 2'b10, 5, 8'h00);
    chk("R10 word read no rvalid", {7'd0, bus_rvalid}, 8'h00);
    chk("R10 word read keeps irq", {7'd0, irq}, 8'h01);
    rd_chk("R10 cause intact", 5, 8'h55);
    rd_chk("R9 out-of-range read", 20, 8'h00);

    // R6: pin reset
    wr(11, 8'h77);
    event_pulse(8'h01, 8'h00);
    @(negedge clk); ext_reset = 1'b1;
    @(negedge clk); ext_reset = 1'b0;
    chk("R6 pin lowers irq", {7'd0, irq}, 8'h00);
    rd_chk("R6 pin config 2", 11, 8'h00);
    rd_chk("R6 pin config 1", 8, 8'h07);
    rd_chk("R6 pin chip code", 14, CHIP);

    // R6: reset command
    wr(12, 8'h12);
    event_pulse(8'h01, 8'h00);
    wr(3, 8'h82);
    chk("R6 command lowers irq", {7'd0, irq}, 8'h00);
    chk("R6 command dma_mode", {7'd0, dma_mode}, 8'h00);
    rd_chk("R6 command config 3", 12, 8'h00);
    rd_chk("R6 command chip code", 14, CHIP);

    // R5: hard reset
    event_pulse(8'h01, 8'h00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R5 hard reset irq", {7'd0, irq}, 8'h00);
    rd_chk("R5 hard reset status", 4, 8'h00);
    rd_chk("R5 hard reset cause", 5, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule